// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five software localities (numbered 0 to 4) currently owns a shared security-device port. Each locality sees one 8-bit control/status byte. A locality writes that byte through a single write port that carries its locality index, and any byte can be read back through a read port indexed the same way. A separate one-hot output shows the current owner to the rest of the chip.

A locality asks for the port by setting its request bit. If nobody owns the port, the request is granted at once. If the port is owned, the request stays pending, and the owner's byte shows that someone is waiting. The owner gives the port up by writing its active bit. There is then one arbitration cycle with no owner, after which the highest-numbered waiting locality takes over. A higher locality may instead take the port by force with the seize bit. The locality that lost the port keeps a sticky flag until it owns the port again or writes that flag to clear it. Every byte also carries a platform flag that reads 1 until an external pulse reports that a trusted OS has been established.

The control is a three-state machine:
- ST_FREE: no owner.
- ST_OWNED: one owner.
- ST_ARB: the single free cycle after a relinquish.

Its transitions are:
- FREE→OWNED on a request or seize.
- OWNED→OWNED on a seize by a higher locality. The owner changes.
- OWNED→ARB on a relinquish by the owner.
- ARB→OWNED when any request is waiting or arrives.
- ARB→FREE when none is.
- FREE→FREE and OWNED→OWNED on every other cycle.

Top module: `loc_own_arbiter`

## Requirements
- R1: After reset no locality is active and every in-range byte reads 8'h81, which is the valid bit (bit 7) plus the not-established flag (bit 0).
- R2: Bit 7 of every in-range locality byte always reads 1. Bits 6 and 3 always read 0.
- R3: While no locality owns the port, a write with bit 1 (request) or bit 3 (seize) set makes the writer the owner at the clock edge that takes the write. The highest-numbered candidate wins.
- R4: A request write from a non-owner sets bit 1 of that locality's byte. While any such request is waiting, bit 2 of the owner's byte reads 1.
- R5: When the owner writes 1 to bit 5, the port has no owner for exactly one cycle. After that cycle, the highest-numbered waiting locality owns it, and its bit 1 clears.
- R6: If nothing is waiting when the owner relinquishes, the port stays free.
- R7: A seize (bit 3) from a locality numbered above the current owner makes the writer the owner in one edge. The old owner's bit 5 clears and its bit 4 sets.
- R8: A seize from a locality numbered at or below the current owner changes nothing.
- R9: Bit 4 of a locality clears when that locality writes 1 to bit 4, or when it becomes the owner again.
- R10: A one-cycle pulse on os_est_i clears bit 0 in all bytes. Bit 0 stays 0 until the next reset.
- R11: active_oh has at most one bit set. Bit i equals bit 5 of locality i's byte.
- R12: Writes with a locality index of 5 or more are ignored. Reads of such an index return 8'h00.
- R13: A relinquish write (bit 5) from a locality that is not the owner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_loc | input | 3 | Locality index of the write |
| wr_data | input | 8 | Command byte: bit1 request, bit3 seize, bit4 clear seized flag, bit5 relinquish |
| rd_loc | input | 3 | Locality index of the readback |
| rd_data | output | 8 | Status byte of rd_loc (combinational) |
| os_est_i | input | 1 | Pulse: a trusted OS has been established |
| active_oh | output | 5 | One-hot current owner, all zero when free |

## Verification
A bad owner register shows at once, both on active_oh and in bit 5 of the bytes. The bench compares all five bytes and active_oh after every write edge and after every idle edge, so such an error is seen one cycle after it arises. A stuck ST_ARB or a missed grant shows as an owner that is still missing one edge after a relinquish. Flags that are lost or stale (request, pending, seized, platform) appear in the affected byte at the first full readback after the write that should have changed them. The bench sweeps every ordered pair of localities through request, seize, relinquish and re-grant to reach each of these cases.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_OWNED = 2'd1,
        ST_ARB   = 2'd2
    } own_state_e;

    // bit positions in each locality byte (read and write share them)
    localparam int B_EST   = 0;
    localparam int B_REQ   = 1;
    localparam int B_PEND  = 2;
    localparam int B_SEIZE = 3;
    localparam int B_SZD   = 4;
    localparam int B_ACT   = 5;
    localparam int B_VALID = 7;

endpackage

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = $clog2(NUM_LOC)
) (
    input  logic [NUM_LOC-1:0] cand,
    output logic [LOC_W-1:0]   pick_idx,
    output logic               pick_any
);

    // highest-numbered candidate wins: later iterations override earlier ones
    always_comb begin
        pick_idx = '0;
        pick_any = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (cand[i]) begin
                pick_idx = LOC_W'(i);
                pick_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/loc_owner_fsm.sv
module loc_owner_fsm
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic               cmd_seize,
    input  logic               cmd_rel,
    input  logic               pick_any,
    input  logic [LOC_W-1:0]   pick_idx,
    output logic [NUM_LOC-1:0] owner_oh,
    output logic [NUM_LOC-1:0] grant_oh,
    output logic [NUM_LOC-1:0] seized_evt_oh
);

    own_state_e       st_q, st_d;
    logic [LOC_W-1:0] own_q, own_d;
    logic             take_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            own_q <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        own_d    = own_q;
        take_evt = 1'b0;
        unique case (st_q)
            ST_FREE, ST_ARB: begin
                if (wr_ok && cmd_seize) begin
                    st_d  = ST_OWNED;
                    own_d = wr_loc;
                end else if (pick_any) begin
                    st_d  = ST_OWNED;
                    own_d = pick_idx;
                end else begin
                    st_d  = ST_FREE;
                end
            end
            ST_OWNED: begin
                if (wr_ok && cmd_rel && (wr_loc == own_q)) begin
                    st_d = ST_ARB;
                end else if (wr_ok && cmd_seize && (wr_loc > own_q)) begin
                    own_d    = wr_loc;
                    take_evt = 1'b1;
                end
            end
            default: st_d = ST_FREE;
        endcase
    end

    // outputs
    always_comb begin
        owner_oh      = (st_q == ST_OWNED) ? (NUM_LOC'(1) << own_q) : '0;
        grant_oh      = '0;
        seized_evt_oh = take_evt ? (NUM_LOC'(1) << own_q) : '0;
        if (st_d == ST_OWNED && (st_q != ST_OWNED || own_d != own_q))
            grant_oh = NUM_LOC'(1) << own_d;
    end

endmodule

// File: rtl/loc_flag_bank.sv
module loc_flag_bank #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] wr_oh,
    input  logic               cmd_req,
    input  logic               cmd_szclr,
    input  logic [NUM_LOC-1:0] owner_oh,
    input  logic [NUM_LOC-1:0] grant_oh,
    input  logic [NUM_LOC-1:0] seized_evt_oh,
    input  logic               os_est_i,
    output logic [NUM_LOC-1:0] req_q,
    output logic [NUM_LOC-1:0] seized_q,
    output logic               est_q
);

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[i]    <= 1'b0;
                seized_q[i] <= 1'b0;
            end else begin
                // grant wins over a new request from the same locality
                if (grant_oh[i])
                    req_q[i] <= 1'b0;
                else if (wr_oh[i] && cmd_req && !owner_oh[i])
                    req_q[i] <= 1'b1;

                if (seized_evt_oh[i])
                    seized_q[i] <= 1'b1;
                else if (grant_oh[i] || (wr_oh[i] && cmd_szclr))
                    seized_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            est_q <= 1'b1;
        else if (os_est_i)
            est_q <= 1'b0;
    end

endmodule

// File: rtl/loc_readback.sv
module loc_readback
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = $clog2(NUM_LOC)
) (
    input  logic [LOC_W-1:0]   rd_loc,
    input  logic [NUM_LOC-1:0] owner_oh,
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] seized_q,
    input  logic               est_q,
    output logic [7:0]         rd_data
);

    logic others_wait;
    assign others_wait = |(req_q & ~owner_oh);

    always_comb begin
        rd_data = 8'h00;
        if (32'(rd_loc) < NUM_LOC) begin
            rd_data[B_VALID] = 1'b1;
            rd_data[B_EST]   = est_q;
            rd_data[B_REQ]   = req_q[rd_loc];
            rd_data[B_ACT]   = owner_oh[rd_loc];
            rd_data[B_SZD]   = seized_q[rd_loc];
            rd_data[B_PEND]  = owner_oh[rd_loc] & others_wait;
        end
    end

endmodule

// File: rtl/loc_own_arbiter.sv
module loc_own_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic [7:0]         wr_data,
    input  logic [LOC_W-1:0]   rd_loc,
    output logic [7:0]         rd_data,
    input  logic               os_est_i,
    output logic [NUM_LOC-1:0] active_oh
);

    logic               wr_ok;
    logic [NUM_LOC-1:0] wr_oh;
    logic               cmd_req, cmd_seize, cmd_rel, cmd_szclr;
    logic [NUM_LOC-1:0] req_q, seized_q, owner_oh, grant_oh, seized_evt_oh;
    logic [NUM_LOC-1:0] cand;
    logic [LOC_W-1:0]   pick_idx;
    logic               pick_any;
    logic               est_q;
    logic               wr_spare_unused;

    assign wr_ok     = wr_en && (32'(wr_loc) < NUM_LOC);
    assign wr_oh     = wr_ok ? (NUM_LOC'(1) << wr_loc) : '0;
    assign cmd_req   = wr_data[B_REQ];
    assign cmd_seize = wr_data[B_SEIZE];
    assign cmd_rel   = wr_data[B_ACT];
    assign cmd_szclr = wr_data[B_SZD];
    assign wr_spare_unused = ^{wr_data[7:6], wr_data[B_PEND], wr_data[B_EST]};

    // waiting requests plus a request arriving this cycle
    assign cand = req_q | (cmd_req ? wr_oh : '0);

    loc_prio_pick #(.NUM_LOC(NUM_LOC)) i_pick (
        .cand     (cand),
        .pick_idx (pick_idx),
        .pick_any (pick_any)
    );

    loc_owner_fsm #(.NUM_LOC(NUM_LOC)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ok         (wr_ok),
        .wr_loc        (wr_loc),
        .cmd_seize     (cmd_seize),
        .cmd_rel       (cmd_rel),
        .pick_any      (pick_any),
        .pick_idx      (pick_idx),
        .owner_oh      (owner_oh),
        .grant_oh      (grant_oh),
        .seized_evt_oh (seized_evt_oh)
    );

    loc_flag_bank #(.NUM_LOC(NUM_LOC)) i_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_oh         (wr_oh),
        .cmd_req       (cmd_req),
        .cmd_szclr     (cmd_szclr),
        .owner_oh      (owner_oh),
        .grant_oh      (grant_oh),
        .seized_evt_oh (seized_evt_oh),
        .os_est_i      (os_est_i),
        .req_q         (req_q),
        .seized_q      (seized_q),
        .est_q         (est_q)
    );

    loc_readback #(.NUM_LOC(NUM_LOC)) i_rb (
        .rd_loc   (rd_loc),
        .owner_oh (owner_oh),
        .req_q    (req_q),
        .seized_q (seized_q),
        .est_q    (est_q),
        .rd_data  (rd_data)
    );

    assign active_oh = owner_oh;

endmodule

// File: rtl/loc_own_arbiter_chk.sv
module loc_own_arbiter_chk #(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = $clog2(NUM_LOC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [LOC_W-1:0]   wr_loc,
    input logic [7:0]         wr_data,
    input logic [NUM_LOC-1:0] active_oh,
    input logic [NUM_LOC-1:0] seized_q,
    input logic               est_q
);

    logic               loc_ok;
    logic [NUM_LOC-1:0] wr_bit;
    assign loc_ok = wr_en && (32'(wr_loc) < NUM_LOC);
    assign wr_bit = NUM_LOC'(1) << wr_loc;

    // R11
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_oh));

    // R3
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ok && (wr_data[1] || wr_data[3]) && active_oh == '0) |=> (active_oh != '0));

    // R5
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ok && wr_data[5] && (active_oh & wr_bit) != '0) |=> (active_oh == '0));

    // R7
    seize_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ok && wr_data[3] && !wr_data[5] && active_oh != '0 && wr_bit > active_oh)
        |=> (active_oh == $past(wr_bit)) && ((seized_q & $past(active_oh)) != '0));

    // R8
    seize_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ok && wr_data[3] && !wr_data[5] && active_oh != '0 && wr_bit <= active_oh)
        |=> $stable(active_oh));

    // R10
    est_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !est_q |=> !est_q);

endmodule

bind loc_own_arbiter loc_own_arbiter_chk #(.NUM_LOC(NUM_LOC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_loc    (wr_loc),
    .wr_data   (wr_data),
    .active_oh (active_oh),
    .seized_q  (seized_q),
    .est_q     (est_q)
);

// File: tb/test_loc_own_arbiter.sv
`timescale 1ns/10ps
module test_loc_own_arbiter;

    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_loc = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_loc = '0;
    logic [7:0] rd_data;
    logic       os_est_i = 1'b0;
    logic [N-1:0] active_oh;

    int checks = 0;
    int errors = 0;

    int       e_own;
    logic [4:0] e_req, e_sz;
    logic     e_est;

    always #5 clk = ~clk;

    loc_own_arbiter i_loc_own_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc),
        .wr_data(wr_data), .rd_loc(rd_loc), .rd_data(rd_data),
        .os_est_i(os_est_i), .active_oh(active_oh)
    );

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; os_est_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_own = -1; e_req = '0; e_sz = '0; e_est = 1'b1;
    endtask

    task automatic do_wr(input int loc, input logic [7:0] d);
        wr_en = 1'b1; wr_loc = 3'(loc); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // compare every byte and the owner vector against the expected flags
    task automatic check_all(input string tag);
        logic [7:0] exp_b;
        logic [N-1:0] exp_oh;
        for (int i = 0; i < 8; i++) begin
            rd_loc = 3'(i);
            #0.2;
            if (i >= N) exp_b = 8'h00;
            else begin
                exp_b = 8'h80;
                exp_b[0] = e_est;
                exp_b[1] = e_req[i];
                exp_b[4] = e_sz[i];
                exp_b[5] = (e_own == i);
                exp_b[2] = (e_own == i) && ((e_req & ~(5'(1) << i)) != 0);
            end
            checks++;
            if (rd_data !== exp_b) begin
                errors++;
                $display("FAIL %s loc %0d: got %02h expected %02h", tag, i, rd_data, exp_b);
            end
        end
        exp_oh = (e_own >= 0) ? (N'(1) << e_own) : '0;
        checks++;
        if (active_oh !== exp_oh) begin
            errors++;
            $display("FAIL %s R11 active_oh: got %b expected %b", tag, active_oh, exp_oh);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // sweep all ordered pairs of distinct localities
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (a == b) continue;
                do_reset();
                check_all("R1 R2 reset");
                do_wr(a, 8'h02); e_own = a;
                check_all("R3 free grant");
                do_wr(b, 8'h02); e_req[b] = 1'b1;
                check_all("R4 pending");
                do_wr(b, 8'h08);
                if (b > a) begin
                    e_own = b; e_req = '0; e_sz[a] = 1'b1;
                    check_all("R7 seize");
                    do_wr(a, 8'h02); e_req[a] = 1'b1;
                    check_all("R4 pending after seize");
                    do_wr(b, 8'h20); e_own = -1;
                    check_all("R5 gap");
                    idle(); e_own = a; e_req = '0; e_sz = '0;
                    check_all("R5 R9 regrant clears seized");
                    do_wr(a, 8'h20); e_own = -1;
                    check_all("R5 gap empty");
                    idle();
                    check_all("R6 stays free");
                end else begin
                    check_all("R8 low seize ignored");
                    do_wr(a, 8'h20); e_own = -1;
                    check_all("R5 gap");
                    idle(); e_own = b; e_req = '0;
                    check_all("R5 grant waiting");
                    do_wr(a, 8'h08); e_own = a; e_sz[b] = 1'b1;
                    check_all("R7 seize back");
                    do_wr(b, 8'h10); e_sz = '0;
                    check_all("R9 write clears seized");
                end
            end
        end

        // highest waiting requester wins
        do_reset();
        do_wr(0, 8'h02); e_own = 0;
        do_wr(1, 8'h02); do_wr(3, 8'h02); do_wr(2, 8'h02); e_req = 5'b01110;
        check_all("R4 three waiting");
        do_wr(0, 8'h20); e_own = -1;
        check_all("R5 gap three");
        idle(); e_own = 3; e_req = 5'b00110;
        check_all("R5 highest wins");
        do_wr(3, 8'h20); e_own = -1; idle(); e_own = 2; e_req = 5'b00010;
        check_all("R5 next highest");
        // out-of-range writes
        for (int k = N; k < 8; k++) begin
            do_wr(k, 8'h3A);
            check_all("R12 out of range ignored");
        end
        do_wr(1, 8'h20);
        check_all("R13 non-owner release ignored");
        do_wr(2, 8'h08);
        check_all("R8 equal seize ignored");
        // platform flag
        os_est_i = 1'b1; @(negedge clk); os_est_i = 1'b0; e_est = 1'b0;
        check_all("R10 flag cleared");
        repeat (3) idle();
        check_all("R10 flag sticky");
        do_reset();
        check_all("R1 R10 reset restores flag");
        // seize while free
        do_wr(1, 8'h08); e_own = 1;
        check_all("R3 seize while free");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule